// File: doc/BRIEF.md
# Configuration Payload Finder

This block sits on a byte stream that carries one configuration file after another. For each file it skips the header and finds where the configuration data begins. It then passes only that payload downstream, on a stream with the same valid/ready/last handshake. A format input, sampled on the first byte of each file, selects how the payload start is found.

In plain-image format the header has two parts. The first is a fixed lead-in. After it come four length-prefixed fields. The block then searches for a run of all-ones bytes and keeps that run as the first bytes of the payload. In packed-image format the block ignores the header layout. It searches the whole file from the first byte for a two-byte marker and drops the marker.

When the block finds the start, it reports the payload's byte offset within the file. When a file ends without a match, it raises a miss flag and forwards nothing. The block never needs random access to the file: a small run counter stands in for a window of recent bytes.

Top module: `cfg_payload_finder`

## Requirements
- R1: After reset, `m_valid`, `start_valid` and `no_preamble` are 0 and `s_ready` is 1.
- R2: `fmt_packed` is sampled on the byte at file offset 0 (1 = packed, 0 = plain) and governs the whole file; changes to it later in the file have no effect.
- R3: In plain format, bytes at offsets 0 to 14 are skipped. The byte at offset 15 is the length L of the first of four fields, and each next field's length byte sits L+3 bytes after the current one. 0xFF bytes anywhere in this region do not count towards the preamble.
- R4: In plain format, the payload starts at the first of four consecutive 0xFF bytes found at or after the byte that follows the fourth field. Those four bytes are forwarded, and `start_offset` equals the offset of the first of them.
- R5: In packed format, the payload starts two bytes after an 0xFF byte that is immediately followed by a byte whose bits [7:4] equal 0x3. The search begins at offset 0. Both marker bytes are dropped, and `start_offset` equals the offset of the 0xFF plus 2.
- R6: Payload bytes leave in file order. `m_last` is set on the file's final byte, and input is accepted in the pass phase only when `m_ready` is 1.
- R7: If a file ends before a match, `no_preamble` goes to 1, no byte of that file is forwarded, and the flag stays set until the next file's first byte is accepted.
- R8: `start_valid` goes to 1 when the match is found and stays at 1, with `start_offset` unchanged, until the next file's first byte is accepted. At that point both `start_valid` and `no_preamble` clear.
- R9: In packed format, a marker whose second byte is the file's final byte reports `start_valid` with the offset, forwards nothing and leaves `no_preamble` at 0.
- R10: While the four plain-format preamble bytes are replayed, `s_ready` is 0 and no input byte is lost.
- R11: Files may follow one another with no gap. Each file is handled independently of the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_packed | input | 1 | Image format, sampled at file offset 0 (1 = packed) |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted when high with `s_valid` |
| s_data | input | 8 | Input file byte |
| s_last | input | 1 | Final byte of the file |
| m_valid | output | 1 | Payload byte valid |
| m_ready | input | 1 | Downstream accepts payload byte |
| m_data | output | 8 | Payload byte |
| m_last | output | 1 | Final payload byte of the file |
| start_valid | output | 1 | Payload start found for the current file |
| start_offset | output | 16 | Byte offset of the payload start within the file |
| no_preamble | output | 1 | File ended without a match |

## Verification
The hardest case to reach is a plain-format preamble that directly follows a header field filled with 0xFF bytes. Here a wrong count of the field boundary shifts the reported offset by a byte or two, yet the output still looks plausible. The stimulus fills the lead-in and every field with 0xFF and sweeps the field lengths and the gap before the preamble, including a near-miss run of three 0xFF. For each combination it drives a throttled downstream, so the preamble replay and the input stall overlap. For packed files, an 0xFF that is not followed by the marker nibble sits right before the real marker.

// File: rtl/bsk_pkg.sv
`timescale 1ns/1ps
package bsk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_SCAN,
        ST_REPLAY,
        ST_PASS
    } bsk_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       last;
    } beat_t;

    localparam logic [7:0] FILL_BYTE  = 8'hFF;
    localparam logic [3:0] PACKED_NIB = 4'h3;

    function automatic logic is_fill(input logic [7:0] b);
        return b == FILL_BYTE;
    endfunction

    function automatic logic is_packed_tag(input logic [7:0] b);
        return b[7:4] == PACKED_NIB;
    endfunction

endpackage

// File: rtl/bsk_field_walk.sv
`timescale 1ns/1ps
// Tracks the lead-in and the length-prefixed header fields (plain format).
module bsk_field_walk
    import bsk_pkg::*;
#(
    parameter int OFF_W      = 16,
    parameter int LEAD_LEN   = 15,
    parameter int N_FIELDS   = 4,
    parameter int FIELD_SPAN = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             step,
    input  logic [OFF_W-1:0] pos,
    input  logic [7:0]       data,
    output logic             hdr_end
);
    localparam int FLD_W = $clog2(N_FIELDS + 1);

    logic [OFF_W-1:0] nxt;
    logic [FLD_W-1:0] fld;
    logic             all_seen;

    assign all_seen = (fld == FLD_W'(N_FIELDS));
    assign hdr_end  = all_seen && ((pos + OFF_W'(1)) == nxt);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            nxt <= OFF_W'(LEAD_LEN);
            fld <= '0;
        end else if (step && !all_seen && (pos == nxt)) begin
            nxt <= pos + OFF_W'(data) + OFF_W'(FIELD_SPAN);
            fld <= fld + FLD_W'(1);
        end
    end

endmodule

// File: rtl/bsk_pre_match.sv
`timescale 1ns/1ps
// Preamble detector: a run counter replaces a window of recent bytes.
module bsk_pre_match
    import bsk_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       step,
    input  logic       packed_mode,
    input  logic [7:0] data,
    output logic       hit
);
    localparam int RUN_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN - 1);

    logic [RUN_W-1:0] run;

    always_comb begin
        if (packed_mode) hit = (run != '0) && is_packed_tag(data);
        else             hit = is_fill(data) && (run == RUN_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= '0;
        end else if (load) begin
            run <= (packed_mode && is_fill(data)) ? RUN_W'(1) : '0;
        end else if (step) begin
            if (!is_fill(data))  run <= '0;
            else if (packed_mode) run <= RUN_W'(1);
            else if (run != RUN_MAX) run <= run + RUN_W'(1);
        end
    end

endmodule

// File: rtl/cfg_payload_finder.sv
`timescale 1ns/1ps
module cfg_payload_finder
    import bsk_pkg::*;
#(
    parameter int OFF_W      = 16,
    parameter int LEAD_LEN   = 15,
    parameter int N_FIELDS   = 4,
    parameter int FIELD_SPAN = 3,
    parameter int RUN_LEN    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fmt_packed,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic [7:0]       s_data,
    input  logic             s_last,
    output logic             m_valid,
    input  logic             m_ready,
    output logic [7:0]       m_data,
    output logic             m_last,
    output logic             start_valid,
    output logic [OFF_W-1:0] start_offset,
    output logic             no_preamble
);
    localparam int REP_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [REP_W-1:0] REP_MAX = REP_W'(RUN_LEN - 1);
    localparam int MIN_PLAIN_OFF = LEAD_LEN + N_FIELDS * FIELD_SPAN;

    bsk_state_e       st;
    logic [OFF_W-1:0] pos;
    logic             packed_q;
    logic             pend_last;
    logic [REP_W-1:0] rep_cnt;
    logic             accept;
    logic             hdr_end;
    logic             hit;
    beat_t            ob;

    assign accept = s_valid && s_ready;

    always_comb begin
        s_ready = 1'b1;
        m_valid = 1'b0;
        ob      = '{data: 8'h00, last: 1'b0};
        case (st)
            ST_REPLAY: begin
                s_ready = 1'b0;
                m_valid = 1'b1;
                ob      = '{data: FILL_BYTE, last: pend_last && (rep_cnt == REP_MAX)};
            end
            ST_PASS: begin
                s_ready = m_ready;
                m_valid = s_valid;
                ob      = '{data: s_data, last: s_last};
            end
            default: ;
        endcase
    end
    assign m_data = ob.data;
    assign m_last = ob.last;

    bsk_field_walk #(
        .OFF_W(OFF_W), .LEAD_LEN(LEAD_LEN), .N_FIELDS(N_FIELDS), .FIELD_SPAN(FIELD_SPAN)
    ) u_walk (
        .clk(clk), .rst(rst),
        .restart(accept && st == ST_IDLE),
        .step(accept && st == ST_HDR),
        .pos(pos), .data(s_data), .hdr_end(hdr_end)
    );

    bsk_pre_match #(.RUN_LEN(RUN_LEN)) u_match (
        .clk(clk), .rst(rst),
        .load(accept && st == ST_IDLE),
        .step(accept && st == ST_SCAN),
        .packed_mode((st == ST_IDLE) ? fmt_packed : packed_q),
        .data(s_data), .hit(hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_IDLE;
            pos          <= '0;
            packed_q     <= 1'b0;
            pend_last    <= 1'b0;
            rep_cnt      <= '0;
            start_valid  <= 1'b0;
            start_offset <= '0;
            no_preamble  <= 1'b0;
        end else begin
            if (accept) pos <= pos + OFF_W'(1);
            case (st)
                ST_IDLE: if (accept) begin
                    pos         <= OFF_W'(1);
                    packed_q    <= fmt_packed;
                    start_valid <= 1'b0;
                    no_preamble <= s_last;
                    if (!s_last) st <= fmt_packed ? ST_SCAN : ST_HDR;
                end
                ST_HDR: if (accept) begin
                    if (s_last) begin
                        no_preamble <= 1'b1;
                        st          <= ST_IDLE;
                    end else if (hdr_end) begin
                        st <= ST_SCAN;
                    end
                end
                ST_SCAN: if (accept) begin
                    if (hit) begin
                        start_valid <= 1'b1;
                        if (packed_q) begin
                            start_offset <= pos + OFF_W'(1);
                            st           <= s_last ? ST_IDLE : ST_PASS;
                        end else begin
                            start_offset <= pos - OFF_W'(RUN_LEN - 1);
                            pend_last    <= s_last;
                            rep_cnt      <= '0;
                            st           <= ST_REPLAY;
                        end
                    end else if (s_last) begin
                        no_preamble <= 1'b1;
                        st          <= ST_IDLE;
                    end
                end
                ST_REPLAY: if (m_ready) begin
                    rep_cnt <= rep_cnt + REP_W'(1);
                    if (rep_cnt == REP_MAX) st <= pend_last ? ST_IDLE : ST_PASS;
                end
                ST_PASS: if (accept && s_last) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R10: input is held while the preamble is replayed
    p_replay_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_REPLAY) |-> !s_ready);

    // R8: no payload byte leaves before its offset is reported
    p_out_after_start_r8: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> start_valid);

    // R8: the report holds until the next file begins
    p_start_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (start_valid && !(st == ST_IDLE && accept)) |=> (start_valid && $stable(start_offset)));

    // R7: a file either matches or misses, never both
    p_found_or_miss_r7: assert property (@(posedge clk) disable iff (rst)
        !(start_valid && no_preamble));

    // R3: a plain-format payload cannot start inside the minimum header
    p_plain_offset_r3: assert property (@(posedge clk) disable iff (rst)
        (start_valid && !packed_q) |-> (start_offset >= OFF_W'(MIN_PLAIN_OFF)));

    // R5: a packed-format payload starts after a two-byte marker
    p_packed_offset_r5: assert property (@(posedge clk) disable iff (rst)
        (start_valid && packed_q) |-> (start_offset >= OFF_W'(2)));

endmodule

// File: tb/tb_cfg_payload_finder.sv
`timescale 1ns/1ps
module tb_cfg_payload_finder;

    logic        clk = 1'b0;
    logic        rst;
    logic        fmt_packed;
    logic        s_valid, s_ready, s_last;
    logic [7:0]  s_data;
    logic        m_valid, m_ready, m_last;
    logic [7:0]  m_data;
    logic        start_valid, no_preamble;
    logic [15:0] start_offset;

    always #2 clk = ~clk;

    cfg_payload_finder dut (
        .clk(clk), .rst(rst), .fmt_packed(fmt_packed),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
        .start_valid(start_valid), .start_offset(start_offset), .no_preamble(no_preamble)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit slow  = 0;
    bit done  = 0;
    logic [7:0] fq[$];
    logic [8:0] expq[$];
    logic [8:0] got[$];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // downstream: throttled ready, sampled away from the edge
    initial begin
        m_ready = 1'b1;
        forever begin
            @(negedge clk);
            m_ready = slow ? ((cyc % 3) != 1) : 1'b1;
            cyc++;
            #1;
            if (m_valid && m_ready) got.push_back({m_last, m_data});
        end
    end

    function automatic logic [7:0] pay_byte(input int k);
        return 8'((k * 53 + 7) & 8'hFF);
    endfunction

    task automatic add_payload(input int n);
        for (int k = 0; k < n; k++) begin
            fq.push_back(pay_byte(k));
            expq.push_back({1'b0, pay_byte(k)});
        end
    endtask

    // plain image: lead-in and field bodies are all 0xFF (R3)
    task automatic build_plain(input int s, input int g, input int n, input bit pre, output int eoff);
        fq.delete(); expq.delete();
        for (int i = 0; i < 15; i++) fq.push_back(8'hFF);
        for (int f = 0; f < 4; f++) begin
            int len = (s + f) % 3;
            fq.push_back(8'(len));
            for (int b = 0; b < len + 2; b++) fq.push_back(8'hFF);
        end
        if (g == 1) fq.push_back(8'h00);
        if (g == 2) begin
            fq.push_back(8'hFF); fq.push_back(8'hFF); fq.push_back(8'hFF); fq.push_back(8'h00);
        end
        eoff = fq.size();
        if (pre) for (int b = 0; b < 4; b++) begin
            fq.push_back(8'hFF);
            expq.push_back(9'h0FF);
        end
        add_payload(n);
        if (!pre) expq.delete();
    endtask

    // packed image: filler with decoys, then 0xFF, 0x3x marker
    task automatic build_packed(input int k, input int n, input bit pre, output int eoff);
        logic [7:0] fill [4] = '{8'h30, 8'hFF, 8'h20, 8'h31};
        fq.delete(); expq.delete();
        for (int i = 0; i < k; i++) fq.push_back(fill[i % 4]);
        if (pre) begin
            fq.push_back(8'hFF);
            fq.push_back(8'h30 | 8'(k & 15));
        end
        eoff = fq.size();
        if (pre) add_payload(n);
    endtask

    task automatic run_file(input bit mode, input bit found, input int eoff, input string req);
        int fails = 0;
        got.delete();
        if (expq.size() > 0) expq[expq.size()-1][8] = 1'b1;
        for (int idx = 0; idx < fq.size(); idx++) begin
            if (slow && (idx % 5 == 4)) begin
                @(negedge clk);
                s_valid = 1'b0;
            end
            @(negedge clk);
            s_valid    = 1'b1;
            s_data     = fq[idx];
            s_last     = (idx == fq.size() - 1);
            fmt_packed = (idx == 0) ? mode : !mode;   // R2: later changes ignored
            #1;
            if (idx == 1) begin
                chk(!start_valid, "R8", "start_valid cleared on new file", start_valid, 0);
                chk(!no_preamble, "R7", "miss flag cleared on new file", no_preamble, 0);
            end
            while (!s_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        s_valid = 1'b0;
        s_last  = 1'b0;
        repeat (16) @(negedge clk);
        #1;
        chk(start_valid == found, req, "start_valid", start_valid, found);
        chk(no_preamble == !found, "R7", "no_preamble", no_preamble, !found);
        if (found) chk(start_offset == 16'(eoff), req, "start_offset", start_offset, eoff);
        chk(got.size() == expq.size(), "R6", "payload byte count", got.size(), expq.size());
        for (int i = 0; i < got.size() && i < expq.size(); i++)
            if (got[i] != expq[i]) fails++;
        // R10: bytes held back during the replay must still arrive intact
        chk(fails == 0, "R6", "payload bytes and last flag", fails, 0);
    endtask

    initial begin
        int eoff;
        rst = 1'b1; s_valid = 1'b0; s_data = '0; s_last = 1'b0; fmt_packed = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(!m_valid && !start_valid && !no_preamble, "R1", "idle outputs after reset",
            {m_valid, start_valid, no_preamble}, 0);
        chk(s_ready, "R1", "s_ready after reset", s_ready, 1);

        // R3 R4 R10 R11: plain sweep over field lengths, gaps, payload sizes
        for (int s = 0; s < 3; s++)
            for (int g = 0; g < 3; g++)
                for (int n = 0; n < 4; n++) begin
                    slow = ((n + g) % 2) == 1;
                    build_plain(s, g, n, 1'b1, eoff);
                    run_file(1'b0, 1'b1, eoff, "R4");
                end

        // R7: plain file with near-miss run and no preamble; file cut inside header
        slow = 1'b0;
        build_plain(0, 2, 3, 1'b0, eoff);
        run_file(1'b0, 1'b0, 0, "R7");
        fq.delete(); expq.delete();
        for (int i = 0; i < 20; i++) fq.push_back(8'hFF);
        run_file(1'b0, 1'b0, 0, "R7");

        // R5 R9 R2: packed sweep, n = 0 puts the marker on the final byte
        for (int k = 0; k < 5; k++)
            for (int n = 0; n < 4; n++) begin
                slow = ((k + n) % 2) == 1;
                build_packed(k, n, 1'b1, eoff);
                run_file(1'b1, 1'b1, eoff, (n == 0) ? "R9" : "R5");
            end

        // R7: packed files that end on a lone 0xFF or hold only decoys
        build_packed(2, 0, 1'b0, eoff);
        run_file(1'b1, 1'b0, 0, "R7");
        build_packed(3, 0, 1'b0, eoff);
        run_file(1'b1, 1'b0, 0, "R7");

        // R11: plain right after packed
        build_plain(1, 0, 2, 1'b1, eoff);
        run_file(1'b0, 1'b1, eoff, "R11");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule